// File: doc/BRIEF.md
# BCD Calendar Clock with Shadow Registers

This block keeps a 24-hour calendar in packed BCD. The calendar holds century, year, month, date, day of week, hours, minutes and seconds. A one-cycle enable that arrives once per second advances a set of hidden counters. Software cannot see those counters. It works only with a bank of shadow registers behind a byte-wide register port. The shadows are refreshed from the counters all at once, one cycle after each second enable.

A control byte carries two halt bits:
- The read bit freezes the shadows so that software can read a consistent snapshot while the hidden counters keep running.
- The write bit also suspends the refresh, so that software can stage a new time in the shadows. When the write bit is cleared, every shadow is copied into the hidden counters in one step.

A stop bit in the top bit of the seconds register holds the count. Software may change it at any time, with or without the write bit set.

Top module: `bcd_calendar_clock`

## Requirements
- R1: Every counter field stays valid packed BCD within its range after each advance: seconds and minutes 00-59, hours 00-23, day of week 1-7, date 01-31, month 01-12, year and century 00-99.
- R2: A tick (`tick_1hz` high for one cycle, stop bit clear) adds one second. Seconds 59 wraps to 00 and carries into minutes. Minutes 59 wraps and carries into hours. Hours 23 wraps to 00 and starts a new day.
- R3: A new day moves the date past the month's last day to 01 of the next month. April, June, September and November have 30 days. February has 28 days in a non-leap year. All other months have 31 days.
- R4: Any year value divisible by 4 is a leap year, and this includes year 00. In a leap year February 28 advances to 29, and February 29 advances to March 01.
- R5: Each new day moves the day of week forward, with 7 wrapping to 1. December rolls over to January of the next year. Year 99 wrapping to 00 increments the century, and century 99 wraps to 00.
- R6: In the cycle after a tick, all eight time shadows are loaded together from the counters, unless a halt bit is set. Reads return the shadow contents. A shadow written while no halt bit is set is overwritten at the next refresh; a refresh in the same cycle as that write takes priority.
- R7: While the read bit (control bit 6) is 1, no refresh takes place and the shadows hold their values. The counters keep advancing. After the bit returns to 0, the next tick refreshes the shadows.
- R8: While the write bit (control bit 7) is 1, no refresh takes place. A control write that clears a set write bit copies all time shadows into the counters at that clock edge. A tick in that same cycle does not advance the counters.
- R9: Bit 7 of the seconds register is the stop bit. Writing it takes effect without the write bit. While it is 1, ticks do not change the counters. It reads back as written.
- R10: Synchronous reset (`rst_n` low) loads 00:00:00, day 1, date 01, month 01, year 00 and century 00. It clears the read, write and stop bits.
- R11: The register map is: address 0 control, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month, 7 year, 8 century. Control bits 5..0 read 0, and addresses 9 and above read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_1hz | input | 1 | One-cycle enable, once per second |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |

## Verification
On every cycle, the assertions check four things:
- Counter fields stay in range, and the year-end and weekday carries are correct.
- Every refresh copies the counters into the shadows exactly, and the shadows stay still while a halt bit is set.
- Clearing the write bit transfers the shadows into the counters.
- The stop bit and idle cycles leave the counters unchanged.

Some behaviour can only be shown through the bench's scenarios, because it depends on long sequences of ticks and carries. This covers the month-length table, the leap-year rule with its year-00 case, and the century carry. It also covers the release of a read halt followed by a refresh, and the overwriting of a shadow write made outside a halt.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int DW         = 8;
  localparam int NUM_FIELDS = 8;

  localparam int A_CTRL = 0;
  localparam int A_SEC  = 1;
  localparam int A_LAST = A_SEC + NUM_FIELDS - 1;

  localparam int CTRL_WR_BIT = 7;
  localparam int CTRL_RD_BIT = 6;
  localparam int STOP_BIT    = 7;

  typedef logic [DW-1:0] bcd_t;

  // Field order matters: sec sits at the least significant byte (index 0).
  typedef struct packed {
    bcd_t cent;
    bcd_t year;
    bcd_t mon;
    bcd_t date;
    bcd_t dow;
    bcd_t hour;
    bcd_t min;
    bcd_t sec;
  } cal_time_t;

  typedef logic [NUM_FIELDS-1:0][DW-1:0] cal_vec_t;

  localparam cal_time_t RESET_TIME = '{cent: 8'h00, year: 8'h00, mon: 8'h01,
                                       date: 8'h01, dow: 8'h01, hour: 8'h00,
                                       min: 8'h00, sec: 8'h00};

  function automatic bcd_t bcd_inc(input bcd_t v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // A two-digit BCD value is divisible by 4 when an even tens digit meets
  // a ones digit of 0/4/8, or an odd tens digit meets 2/6.
  function automatic logic bcd_leap(input bcd_t y);
    logic ones_even_set;
    logic ones_odd_set;
    ones_even_set = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    ones_odd_set  = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return y[4] ? ones_odd_set : ones_even_set;
  endfunction

  function automatic bcd_t bcd_month_days(input bcd_t mon, input logic leap);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic bcd_ok(input bcd_t v, input bcd_t lo, input bcd_t hi);
    return (v[3:0] <= 4'd9) && (v >= lo) && (v <= hi);
  endfunction

  function automatic logic cal_in_range(input cal_time_t t);
    return bcd_ok(t.sec, 8'h00, 8'h59) && bcd_ok(t.min, 8'h00, 8'h59) &&
           bcd_ok(t.hour, 8'h00, 8'h23) && bcd_ok(t.dow, 8'h01, 8'h07) &&
           bcd_ok(t.date, 8'h01, 8'h31) && bcd_ok(t.mon, 8'h01, 8'h12) &&
           bcd_ok(t.year, 8'h00, 8'h99) && bcd_ok(t.cent, 8'h00, 8'h99);
  endfunction
endpackage

// File: rtl/cal_counters.sv
module cal_counters
  import cal_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      adv,
  input  logic      load,
  input  cal_time_t load_val,
  output cal_time_t cur
);
  logic      sec_wrap, min_wrap, day_roll, month_end, year_end, cent_carry;
  bcd_t      month_len;
  cal_time_t nxt;

  // Carry chain, named for the assertions.
  assign month_len  = bcd_month_days(cur.mon, bcd_leap(cur.year));
  assign sec_wrap   = (cur.sec == 8'h59);
  assign min_wrap   = sec_wrap && (cur.min == 8'h59);
  assign day_roll   = min_wrap && (cur.hour == 8'h23);
  assign month_end  = day_roll && (cur.date >= month_len);
  assign year_end   = month_end && (cur.mon == 8'h12);
  assign cent_carry = year_end && (cur.year == 8'h99);

  always_comb begin
    nxt      = cur;
    nxt.sec  = sec_wrap ? 8'h00 : bcd_inc(cur.sec);
    if (sec_wrap)   nxt.min  = min_wrap ? 8'h00 : bcd_inc(cur.min);
    if (min_wrap)   nxt.hour = day_roll ? 8'h00 : bcd_inc(cur.hour);
    if (day_roll) begin
      nxt.dow  = (cur.dow == 8'h07) ? 8'h01 : bcd_inc(cur.dow);
      nxt.date = month_end ? 8'h01 : bcd_inc(cur.date);
    end
    if (month_end)  nxt.mon  = year_end ? 8'h01 : bcd_inc(cur.mon);
    if (year_end)   nxt.year = cent_carry ? 8'h00 : bcd_inc(cur.year);
    if (cent_carry) nxt.cent = (cur.cent == 8'h99) ? 8'h00 : bcd_inc(cur.cent);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    cur <= RESET_TIME;
    else if (load) cur <= load_val;
    else if (adv)  cur <= nxt;
  end

  AST_FIELD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && cal_in_range(cur)) |=> cal_in_range(cur)); // R1
  AST_MINUTE_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && cur.sec == 8'h59 && cur.min == 8'h09) |=> (cur.sec == 8'h00 && cur.min == 8'h10)); // R2
  AST_WEEKDAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && cur.hour == 8'h23 && cur.min == 8'h59 && cur.sec == 8'h59 && cur.dow == 8'h07) |=> (cur.dow == 8'h01)); // R5
  AST_YEAR_END: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && day_roll && cur.mon == 8'h12 && cur.date == 8'h31) |=> (cur.mon == 8'h01 && cur.date == 8'h01)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !load) |=> $stable(cur)); // R9
endmodule

// File: rtl/cal_shadow.sv
module cal_shadow
  import cal_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  cal_vec_t          cnt_vec,
  output cal_vec_t          sh_vec,
  output logic              stop,
  output logic              load
);
  localparam cal_vec_t          RST_VEC = RESET_TIME;
  localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(A_CTRL);
  localparam logic [ADDR_W-1:0] SEC_A   = ADDR_W'(A_SEC);

  logic rd_halt, wr_halt, upd_q, refresh, ctrl_wr;

  assign ctrl_wr = reg_we && (reg_addr == CTRL_A);
  assign refresh = upd_q && !rd_halt && !wr_halt;
  assign load    = ctrl_wr && wr_halt && !reg_wdata[CTRL_WR_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_halt <= 1'b0;
      wr_halt <= 1'b0;
      upd_q   <= 1'b0;
      stop    <= 1'b0;
    end else begin
      upd_q <= tick;
      if (ctrl_wr) begin
        rd_halt <= reg_wdata[CTRL_RD_BIT];
        wr_halt <= reg_wdata[CTRL_WR_BIT];
      end
      if (reg_we && reg_addr == SEC_A) stop <= reg_wdata[STOP_BIT];
    end
  end

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    localparam logic [ADDR_W-1:0] FA = ADDR_W'(A_SEC + i);
    logic [DW-1:0] wval;
    if (i == 0) begin : g_sec
      assign wval = {1'b0, reg_wdata[DW-2:0]};
    end else begin : g_plain
      assign wval = reg_wdata;
    end
    always_ff @(posedge clk) begin
      if (!rst_n)                         sh_vec[i] <= RST_VEC[i];
      else if (refresh)                   sh_vec[i] <= cnt_vec[i];
      else if (reg_we && reg_addr == FA)  sh_vec[i] <= wval;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CTRL_A) begin
      reg_rdata[CTRL_WR_BIT] = wr_halt;
      reg_rdata[CTRL_RD_BIT] = rd_halt;
    end else if (reg_addr == SEC_A) begin
      reg_rdata = sh_vec[0];
      reg_rdata[STOP_BIT] = stop;
    end else if (int'(reg_addr) <= A_LAST) begin
      reg_rdata = sh_vec[int'(reg_addr) - A_SEC];
    end
  end

  AST_REFRESH_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> (sh_vec == $past(cnt_vec))); // R6
  AST_READ_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_halt && !reg_we) |=> $stable(sh_vec)); // R7
  AST_WRITE_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_halt && !reg_we) |=> $stable(sh_vec)); // R8
  AST_CTRL_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == CTRL_A) |-> (reg_rdata[5:0] == 6'd0)); // R11
endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
  import cal_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata
);
  cal_time_t cnt_time, shadow_time;
  cal_vec_t  cnt_vec, sh_vec;
  logic      stop, load, adv;

  assign cnt_vec     = cnt_time;
  assign shadow_time = sh_vec;
  assign adv         = tick_1hz && !stop && !load;

  cal_shadow #(.ADDR_W(ADDR_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cnt_vec(cnt_vec), .sh_vec(sh_vec), .stop(stop), .load(load)
  );

  cal_counters u_counters (
    .clk(clk), .rst_n(rst_n), .adv(adv), .load(load),
    .load_val(shadow_time), .cur(cnt_time)
  );

  AST_LOAD_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_time == $past(shadow_time))); // R8
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !load) |=> $stable(cnt_time)); // R9
  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |=> (cnt_time == RESET_TIME && !stop)); // R10
endmodule

// File: tb/bcd_calendar_clock_tb.sv
module bcd_calendar_clock_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic       reg_we = 1'b0;
  logic [3:0] reg_addr = 4'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;

  always #4 clk = ~clk;

  bcd_calendar_clock u_dut (.clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  // Reference model, decimal integers. Index order: sec,min,hour,dow,date,mon,year,cent.
  int    m_cnt[8];
  int    m_sh[8];
  bit    m_stop, m_rb, m_wb, m_upd;
  int    n_cmp = 0;
  int    n_bad = 0;
  int    rr = 0;
  string cur_req = "R10";

  function automatic int to_bcd(int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction
  function automatic int from_bcd(int v);
    return ((v >> 4) & 15) * 10 + (v & 15);
  endfunction
  function automatic int days_in(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  task automatic model_reset();
    m_cnt = '{0, 0, 0, 1, 1, 1, 0, 0};
    m_sh  = m_cnt;
    m_stop = 0; m_rb = 0; m_wb = 0; m_upd = 0;
  endtask

  task automatic model_advance();
    m_cnt[0]++;
    if (m_cnt[0] < 60) return;
    m_cnt[0] = 0; m_cnt[1]++;
    if (m_cnt[1] < 60) return;
    m_cnt[1] = 0; m_cnt[2]++;
    if (m_cnt[2] < 24) return;
    m_cnt[2] = 0;
    m_cnt[3] = (m_cnt[3] % 7) + 1;
    if (m_cnt[4] < days_in(m_cnt[5], m_cnt[6])) begin m_cnt[4]++; return; end
    m_cnt[4] = 1;
    if (m_cnt[5] < 12) begin m_cnt[5]++; return; end
    m_cnt[5] = 1;
    if (m_cnt[6] < 99) begin m_cnt[6]++; return; end
    m_cnt[6] = 0;
    m_cnt[7] = (m_cnt[7] + 1) % 100;
  endtask

  task automatic model_edge(bit we, int addr, int wd, bit tk);
    int  old_cnt[8];
    bit  ld;
    if (!rst_n) begin model_reset(); return; end
    old_cnt = m_cnt;
    ld = we && addr == 0 && m_wb && !wd[7];
    if (ld) m_cnt = m_sh;
    else if (tk && !m_stop) model_advance();
    if (m_upd && !m_rb && !m_wb) m_sh = old_cnt;
    else if (we && addr >= 1 && addr <= 8) m_sh[addr-1] = from_bcd(addr == 1 ? (wd & 8'h7f) : wd);
    if (we && addr == 1) m_stop = wd[7];
    if (we && addr == 0) begin m_rb = wd[6]; m_wb = wd[7]; end
    m_upd = tk;
  endtask

  function automatic int expect_rd(int addr);
    if (addr == 0) return (int'(m_wb) << 7) | (int'(m_rb) << 6);
    if (addr == 1) return (int'(m_stop) << 7) | to_bcd(m_sh[0]);
    if (addr <= 8) return to_bcd(m_sh[addr-1]);
    return 0;
  endfunction

  task automatic compare();
    int e;
    e = expect_rd(int'(reg_addr));
    n_cmp++;
    if (int'(reg_rdata) != e) begin
      n_bad++;
      $display("FAIL %s addr %0d actual %02h expected %02h at %0t",
               cur_req, reg_addr, reg_rdata, e[7:0], $time);
    end
  endtask

  task automatic step(bit we, int addr, int wd, bit tk);
    reg_we = we; reg_addr = addr[3:0]; reg_wdata = wd[7:0]; tick_1hz = tk;
    @(posedge clk);
    model_edge(we, addr, wd, tk);
    #2;
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      rr = (rr + 1) % 11;
      step(0, rr, 0, 0);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      rr = (rr + 1) % 11;
      step(0, rr, 0, 1);
      idle(2);
    end
  endtask

  task automatic wr(int addr, int val);
    step(1, addr, val, 0);
  endtask

  task automatic set_time(int c, int y, int mo, int d, int w, int h, int mi, int s);
    wr(0, 8'h80);
    wr(1, to_bcd(s)); wr(2, to_bcd(mi)); wr(3, to_bcd(h)); wr(4, to_bcd(w));
    wr(5, to_bcd(d)); wr(6, to_bcd(mo)); wr(7, to_bcd(y)); wr(8, to_bcd(c));
    wr(0, 8'h00);
    idle(11);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
    $finish;
  end

  initial begin
    model_reset();
    rst_n = 1'b0;
    repeat (3) step(0, 0, 0, 0);
    rst_n = 1'b1;
    cur_req = "R10"; idle(11);
    cur_req = "R11"; idle(11);

    cur_req = "R2"; ticks(3);
    set_time(20, 23, 5, 10, 3, 22, 58, 57); ticks(5);
    set_time(20, 23, 5, 10, 3, 23, 59, 58); ticks(3);

    cur_req = "R3";
    set_time(20, 23, 4, 30, 2, 23, 59, 59); ticks(2);
    set_time(20, 23, 1, 31, 2, 23, 59, 59); ticks(2);
    set_time(20, 23, 2, 28, 2, 23, 59, 59); ticks(2);
    set_time(20, 23, 11, 30, 2, 23, 59, 59); ticks(2);

    cur_req = "R4";
    set_time(20, 24, 2, 28, 4, 23, 59, 59); ticks(2);
    set_time(20, 24, 2, 29, 4, 23, 59, 59); ticks(2);
    set_time(21, 0, 2, 28, 1, 23, 59, 59); ticks(2);

    cur_req = "R5";
    set_time(19, 99, 12, 31, 7, 23, 59, 59); ticks(2);
    set_time(99, 99, 12, 31, 6, 23, 59, 59); ticks(2);

    cur_req = "R1"; ticks(70);

    cur_req = "R6";
    wr(2, 8'h33); idle(3); ticks(2);
    step(1, 3, 8'h11, 1); step(1, 3, 8'h12, 0); idle(11);

    cur_req = "R7";
    wr(0, 8'h40); ticks(5); idle(11);
    wr(0, 8'h00); idle(11); ticks(2);

    cur_req = "R8";
    wr(0, 8'h80); ticks(3); wr(2, 8'h45); wr(5, 8'h15); idle(11);
    step(1, 0, 8'h00, 1); idle(11); ticks(3);

    cur_req = "R9";
    wr(1, 8'h80); ticks(4); idle(11);
    wr(1, 8'h00); idle(3); ticks(3);

    cur_req = "R10";
    rst_n = 1'b0; step(0, 0, 0, 1); step(0, 1, 0, 0);
    rst_n = 1'b1; idle(11);

    report();
    $finish;
  end
endmodule